// File: doc/BRIEF.md
# Chained Periodic Interrupt Source

This block raises an interrupt request at a fixed period and answers acknowledgements on a chain shared with other interrupt sources. A free-running interval counter sets a pending flag every `INTERVAL` clock edges. The pending flag drives the request output. On a shared line, a 1 means the device drives the line high and a 0 means it releases the line. An external wired-OR combines the requests of every device on the chain.

The processor sends one acknowledge into the head of the chain. A device with a pending request keeps that acknowledge for itself. On the next edge it drops its request, and for one cycle it enables its 32-bit identifier onto the shared data bus. A device with nothing pending passes the acknowledge unchanged to its acknowledge output, which feeds the next device. The order of the chain therefore sets a fixed priority. The bus drive is modelled as an enable plus a data word that reads all zero while the enable is low, so the data words of several devices can be ORed.

Top module: `chain_tick_timer`

## Requirements
- R1: A synchronous active-high reset clears the interval count, the pending flag and the bus enable, so `irq_o`, `bus_en_o` and `bus_data_o` read 0 after the reset edge. The first interval after reset is measured from the edge at which reset is released.
- R2: Counting clock edges with reset low, where edge 1 is the first such edge, `irq_o` is 0 after edges 1 to `INTERVAL-1` and becomes 1 after edge `INTERVAL` (2000 by default).
- R3: The counter restarts at the edge that raises a request, so requests are raised at edges k·`INTERVAL`, whatever the acknowledge traffic is.
- R4: Once raised, `irq_o` stays 1 until an edge at which `ack_in_i` is 1. After that edge `irq_o` is 0, unless R9 applies.
- R5: After an edge at which `ack_in_i` is 1 while a request is pending, `bus_en_o` is 1 for the next cycle and `bus_data_o` carries `DEV_ID`, a 32-bit constant whose default is 0x0.
- R6: In every cycle that does not follow such an absorbing edge, `bus_en_o` is 0 and `bus_data_o` is all zero.
- R7: While no request is pending and the device is not answering, `ack_out_o` follows `ack_in_i` in the same cycle, with no register in the path.
- R8: `ack_out_o` is 0 while a request is pending and during the answering cycle, so no downstream device sees the acknowledge.
- R9: When the interval expires on the same edge that absorbs an acknowledge, the device answers (R5) and `irq_o` stays 1 for the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| ack_in_i | input | 1 | Acknowledge arriving from the upstream side of the chain |
| irq_o | output | 1 | Request: 1 drives the shared line high, 0 releases it |
| ack_out_o | output | 1 | Acknowledge passed to the next device in the chain |
| bus_en_o | output | 1 | Output enable of the modelled tri-state data driver |
| bus_data_o | output | 32 | Identifier while enabled, all zero otherwise |

## Verification
A raised request appears after the same edge that ends the interval. The bus enable and identifier appear one edge after the acknowledge is sampled, and the acknowledge pass-through is combinational within the cycle. The bench counts edges since reset release, drives `ack_in_i` just after a falling edge, and checks `ack_out_o` one time unit later, in the same cycle. It checks the registered outputs at that falling edge, which reflect the rising edge just passed. The vectors are placed at edges INTERVAL−1 and INTERVAL, at the cycle of each acknowledge and the one after, at an acknowledge that lands on an expiry edge, and after a reset that arrives in the middle of an interval.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

    localparam int unsigned DATA_W = 32;

    typedef logic [DATA_W-1:0] word_t;

    // Modelled tri-state drive: enable plus a word that is zero when disabled
    typedef struct packed {
        logic  en;
        word_t data;
    } bus_drive_t;

    function automatic word_t gate_word(input logic en, input word_t w);
        return en ? w : '0;
    endfunction

    function automatic int unsigned ctr_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ctt_interval_ctr.sv
module ctt_interval_ctr
    import ctt_pkg::*;
#(
    parameter int unsigned INTERVAL = 2000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic expire_o
);

    localparam int unsigned CW   = ctr_bits(INTERVAL);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    // Restart on the edge that ends the interval
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = (cnt_q == LAST);

    generate
        if (INTERVAL >= 2) begin : g_gap
            // R3: two expiries never fall on neighbouring edges
            assert_expiry_spaced_R3: assert property (@(posedge clk_i) disable iff (rst_i)
                expire_o |=> !expire_o)
                else $error("expiry on consecutive edges");
        end
    endgenerate

endmodule

// File: rtl/ctt_answer_ctl.sv
module ctt_answer_ctl
    import ctt_pkg::*;
#(
    parameter word_t DEV_ID = '0
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       expire_i,
    input  logic       ack_i,
    output logic       pending_o,
    output bus_drive_t drive_o
);

    logic pending_q;
    logic answer_q;
    logic absorb;

    assign absorb = pending_q & ack_i;

    // A new expiry wins over the clearing acknowledge on the same edge
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pending_q <= 1'b0;
            answer_q  <= 1'b0;
        end else begin
            answer_q <= absorb;
            if (expire_i) begin
                pending_q <= 1'b1;
            end else if (absorb) begin
                pending_q <= 1'b0;
            end
        end
    end

    assign pending_o    = pending_q;
    assign drive_o.en   = answer_q;
    assign drive_o.data = gate_word(answer_q, DEV_ID);

    // R2: a request is only ever raised by an interval expiry
    assert_raise_on_expiry_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pending_q) |-> $past(expire_i))
        else $error("request raised without expiry");

    // R4: without an acknowledge the request is held
    assert_request_held_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (pending_q && !ack_i) |=> pending_q)
        else $error("request dropped without acknowledge");

    // R4: an absorbed acknowledge clears the request when no expiry coincides
    assert_request_dropped_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (pending_q && ack_i && !expire_i) |=> !pending_q)
        else $error("request kept after acknowledge");

    // R5: an absorbed acknowledge is answered on the next cycle
    assert_answer_next_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (pending_q && ack_i) |=> drive_o.en)
        else $error("acknowledge not answered");

    // R6: the bus is enabled only after an absorbing edge
    assert_answer_only_after_ack_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        drive_o.en |-> ($past(pending_q) && $past(ack_i)))
        else $error("bus enabled without acknowledge");

    // R9: expiry coinciding with acknowledge keeps the request and answers
    assert_coincide_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (pending_q && ack_i && expire_i) |=> (pending_q && drive_o.en))
        else $error("coinciding expiry mishandled");

endmodule

// File: rtl/ctt_ack_pass.sv
module ctt_ack_pass (
    input  logic ack_i,
    input  logic pending_i,
    input  logic answering_i,
    output logic ack_o
);

    // Pass the acknowledge downstream only while this device stays silent
    assign ack_o = ack_i & ~pending_i & ~answering_i;

endmodule

// File: rtl/chain_tick_timer.sv
module chain_tick_timer
    import ctt_pkg::*;
#(
    parameter int unsigned INTERVAL = 2000,
    parameter word_t       DEV_ID   = '0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ack_in_i,
    output logic              irq_o,
    output logic              ack_out_o,
    output logic              bus_en_o,
    output logic [DATA_W-1:0] bus_data_o
);

    logic       expire;
    logic       pending;
    bus_drive_t drive;

    ctt_interval_ctr #(
        .INTERVAL (INTERVAL)
    ) u_ctr (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .expire_o (expire)
    );

    ctt_answer_ctl #(
        .DEV_ID (DEV_ID)
    ) u_answer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .expire_i  (expire),
        .ack_i     (ack_in_i),
        .pending_o (pending),
        .drive_o   (drive)
    );

    ctt_ack_pass u_pass (
        .ack_i       (ack_in_i),
        .pending_i   (pending),
        .answering_i (drive.en),
        .ack_o       (ack_out_o)
    );

    assign irq_o      = pending;
    assign bus_en_o   = drive.en;
    assign bus_data_o = drive.data;

    // R7: nothing reaches downstream that did not arrive from upstream
    assert_pass_from_upstream_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        ack_out_o |-> ack_in_i)
        else $error("acknowledge out without acknowledge in");

    // R8: the chain is blocked while requesting or answering
    assert_block_chain_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o || bus_en_o) |-> !ack_out_o)
        else $error("acknowledge leaked downstream");

    // R6: the data word carries the identifier when enabled
    assert_id_on_bus_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_en_o |-> (bus_data_o == DEV_ID))
        else $error("wrong identifier on bus");

endmodule

// File: tb/chain_tick_timer_tb_top.sv
module chain_tick_timer_tb_top;

    localparam int unsigned N  = 2000;
    localparam logic [31:0] ID = 32'hC0DE_0003;

    typedef struct packed {
        int   t;
        int   req;
        logic ack;
        logic irq;
        logic en;
        logic ao;
    } row_t;

    localparam int ROWS = 21;
    // t: edge after which the row is applied; ack drives the following edge
    localparam row_t TBL [ROWS] = '{
        '{1,     7, 1'b1, 1'b0, 1'b0, 1'b1},  // R7 idle pass
        '{1999,  2, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 not yet
        '{2000,  8, 1'b1, 1'b1, 1'b0, 1'b0},  // R8 pending blocks
        '{2001,  5, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 answer, R8 blocked
        '{2002,  6, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 released
        '{2003,  7, 1'b1, 1'b0, 1'b0, 1'b1},  // R7 pass again
        '{3999,  3, 1'b0, 1'b0, 1'b0, 1'b0},  // R3
        '{4000,  3, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 second raise
        '{4500,  4, 1'b0, 1'b1, 1'b0, 1'b0},  // R4 held
        '{4501,  8, 1'b1, 1'b1, 1'b0, 1'b0},  // R8
        '{4502,  4, 1'b0, 1'b0, 1'b1, 1'b0},  // R4 dropped
        '{4503,  6, 1'b0, 1'b0, 1'b0, 1'b0},  // R6
        '{5999,  3, 1'b0, 1'b0, 1'b0, 1'b0},  // R3
        '{6000,  3, 1'b0, 1'b1, 1'b0, 1'b0},  // R3
        '{7999,  4, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 still held
        '{8000,  9, 1'b0, 1'b1, 1'b1, 1'b0},  // R9 answer and new request
        '{8001,  9, 1'b1, 1'b1, 1'b0, 1'b0},  // R9
        '{8002,  5, 1'b0, 1'b0, 1'b1, 1'b0},  // R5
        '{8003,  6, 1'b0, 1'b0, 1'b0, 1'b0},  // R6
        '{9999,  3, 1'b0, 1'b0, 1'b0, 1'b0},  // R3
        '{10000, 3, 1'b0, 1'b1, 1'b0, 1'b0}   // R3
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        ack_in;
    logic        irq;
    logic        ack_out;
    logic        bus_en;
    logic [31:0] bus_data;

    int edges;
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    chain_tick_timer #(
        .INTERVAL (N),
        .DEV_ID   (ID)
    ) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .ack_in_i   (ack_in),
        .irq_o      (irq),
        .ack_out_o  (ack_out),
        .bus_en_o   (bus_en),
        .bus_data_o (bus_data)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s at edge %0d: got %0h expected %0h",
                     req, what, edges, act, exp);
        end
    endtask

    task automatic check_outs(input int req, input logic e_irq,
                              input logic e_en, input logic e_ao);
        check(req, "irq", {31'b0, irq}, {31'b0, e_irq});
        check(req, "bus_en", {31'b0, bus_en}, {31'b0, e_en});
        check(req, "bus_data", bus_data, e_en ? ID : 32'h0);
        check(req, "ack_out", {31'b0, ack_out}, {31'b0, e_ao});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired at edge %0d", edges);
        finish_run();
    end

    initial begin
        rst    = 1'b1;
        ack_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state after reset
        check_outs(1, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < ROWS; i++) begin
            while (edges < TBL[i].t) @(negedge clk);
            ack_in = TBL[i].ack;
            #1;
            check_outs(TBL[i].req, TBL[i].irq, TBL[i].en, TBL[i].ao);
            @(negedge clk);
            ack_in = 1'b0;
        end

        // R1: reset in mid-interval while a request is pending (raised at 10000)
        while (edges < 10500) @(negedge clk);
        #1;
        check(1, "irq before reset", {31'b0, irq}, 32'h1);
        rst = 1'b1;
        @(negedge clk);
        check_outs(1, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        // R2: the first interval is measured afresh from release
        while (edges < N - 1) @(negedge clk);
        #1;
        check(2, "irq one edge early after reset", {31'b0, irq}, 32'h0);
        @(negedge clk);
        #1;
        check(2, "irq at interval after reset", {31'b0, irq}, 32'h1);

        // R7: acknowledge passes while idle; R5/R6 answer of the new request
        ack_in = 1'b1;
        #1;
        check_outs(8, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        #1;
        check_outs(5, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        #1;
        check_outs(7, 1'b0, 1'b0, 1'b1);
        ack_in = 1'b0;
        #1;
        check(6, "ack_out with ack low", {31'b0, ack_out}, 32'h0);

        finish_run();
    end

endmodule